// File: doc/BRIEF.md
# Fetch-Stage Branch Target Buffer

This block predicts the next fetch address for an in-order pipeline. Each cycle the fetch PC indexes a direct-mapped table in the same cycle as the instruction-cache read. A matching valid entry marks the fetched word as a branch. It returns the stored target, a taken/not-taken guess and whether the branch is unconditional, and it steers `next_pc`. Without a match, fetch falls through to PC+4.

Later, the resolving stage reports each branch outcome together with the prediction that fetch acted on. The block rewrites or allocates the entry and compares the outcome with that prediction. On a wrong guess it raises `flush` for one cycle, which empties the pipeline latches, and presents the correct-path address on `redirect_pc`.

Direction history is a 2-bit saturating counter per entry with four named states: STRONG_NT (0), WEAK_NT (1), WEAK_T (2) and STRONG_T (3). A taken outcome moves the counter one step toward STRONG_T and a not-taken outcome moves it one step toward STRONG_NT. The flush controller has two named states, RUN and FLUSH:
- RUN goes to FLUSH on a detected mispredict.
- RUN stays in RUN otherwise.
- FLUSH always returns to RUN after one cycle.

Top module: `btb_predictor`

## Requirements
- R1: After reset every entry is invalid. Any lookup misses with `pred_hit`, `pred_taken`, `pred_uncond` and `pred_target` all 0, `flush` is 0 and `redirect_pc` is 0.
- R2: The lookup is combinational on `fetch_pc`. The entry index is `fetch_pc[7:2]` (64 entries) and the tag is `fetch_pc[31:8]`. A hit needs a valid entry whose tag matches, and a same-index, different-tag PC misses.
- R3: On a miss `pred_taken` is 0 and `next_pc` equals `fetch_pc`+4. On a predicted-taken hit `next_pc` equals `pred_target`.
- R4: A resolved branch (`res_is_branch`=1) that is taken and has no matching entry is written into its index, replacing any other tag there. The write stores the tag, the target, the type and counter WEAK_T (2), and it is visible to lookups from the next cycle.
- R5: A not-taken branch without a matching entry allocates nothing. A resolve with `res_is_branch`=0 never changes the table.
- R6: A resolved branch that hits its entry steps the counter. Taken increments it up to a ceiling of 3 and not-taken decrements it down to a floor of 0. A conditional hit predicts taken only when the counter is 2 or 3.
- R7: A hit on an entry whose type bit says unconditional (`res_uncond`=1 at its last write) is predicted taken whatever the counter holds.
- R8: A taken resolve that hits rewrites the stored target. A not-taken resolve leaves the stored target unchanged.
- R9: A mispredict is flagged when any of these holds:
  - taken was not predicted but the branch was taken;
  - taken was predicted but the branch was not taken;
  - both predicted and actual are taken but `res_pred_target` differs from `res_target`.

  In the cycle after a mispredict `flush` is 1 and `redirect_pc` is `res_target` if taken, else `res_pc`+4.
- R10: A resolve whose prediction matched (same direction, and same target when taken) leaves `flush` at 0 in the next cycle.
- R11: `flush` lasts exactly one cycle. A resolve presented during the flush cycle is wrong-path and is ignored: no table change and no mispredict.
- R12: When a table write and a lookup touch the same index in one cycle, the lookup returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | 32 | Address being fetched this cycle |
| pred_hit | output | 1 | Table holds a branch at this address |
| pred_taken | output | 1 | Fetch should follow the predicted target |
| pred_uncond | output | 1 | Hit entry is an unconditional branch |
| pred_target | output | 32 | Stored target on a hit, else 0 |
| next_pc | output | 32 | Predicted next fetch address |
| res_valid | input | 1 | A resolved instruction is presented |
| res_is_branch | input | 1 | The resolved instruction is a branch |
| res_uncond | input | 1 | The resolved branch is unconditional |
| res_pc | input | 32 | Address of the resolved instruction |
| res_taken | input | 1 | Actual direction |
| res_target | input | 32 | Actual target |
| res_pred_taken | input | 1 | Direction that fetch followed |
| res_pred_target | input | 32 | Target that fetch followed |
| flush | output | 1 | Empty the pipeline latches this cycle |
| redirect_pc | output | 32 | Correct-path fetch address, valid with flush |

## Verification
The prediction outputs depend only on `fetch_pc` and the table, so they are due in the cycle the address is applied. The bench samples them one nanosecond after driving the address. Table writes happen at the clock edge that ends the resolve cycle, so their effect on a lookup is first expected in the following cycle. That is also the cycle in which `flush` and `redirect_pc`, one register behind the resolve, are checked. The reference model applies its own table update and flush decision only after that same edge, so every comparison on every clock uses the state the design should hold at that point.

// File: rtl/btb_pkg.sv
package btb_pkg;

    // two-bit direction history, named by strength
    typedef enum logic [1:0] {
        CTR_SNT = 2'd0,
        CTR_WNT = 2'd1,
        CTR_WT  = 2'd2,
        CTR_ST  = 2'd3
    } ctr_e;

    // flush controller states
    typedef enum logic {
        FL_RUN   = 1'b0,
        FL_FLUSH = 1'b1
    } flush_e;

    // saturating step of the history counter
    function automatic ctr_e ctr_step(ctr_e cur, logic taken);
        ctr_e nxt;
        unique case (cur)
            CTR_SNT: nxt = taken ? CTR_WNT : CTR_SNT;
            CTR_WNT: nxt = taken ? CTR_WT  : CTR_SNT;
            CTR_WT:  nxt = taken ? CTR_ST  : CTR_WNT;
            CTR_ST:  nxt = taken ? CTR_ST  : CTR_WT;
            default: nxt = CTR_WT;
        endcase
        return nxt;
    endfunction

    // a counter in the upper half predicts taken
    function automatic logic ctr_says_taken(ctr_e c);
        return (c == CTR_WT) || (c == CTR_ST);
    endfunction

endpackage

// File: rtl/btb_store.sv
module btb_store
    import btb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int PC_W    = 32,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int TAG_W  = PC_W - IDX_W - 2
) (
    input  logic             clk,
    input  logic             rst_n,
    // lookup read port
    input  logic [IDX_W-1:0] lk_idx,
    output logic             lk_valid,
    output logic [TAG_W-1:0] lk_tag,
    output logic [PC_W-1:0]  lk_target,
    output ctr_e             lk_ctr,
    output logic             lk_uncond,
    // update port
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic [TAG_W-1:0] upd_tag,
    input  logic             upd_taken,
    input  logic             upd_uncond,
    input  logic [PC_W-1:0]  upd_target
);

    logic [ENTRIES-1:0] vld_vec;
    logic [TAG_W-1:0]   tag_arr [ENTRIES];
    logic [PC_W-1:0]    tgt_arr [ENTRIES];
    ctr_e               ctr_arr [ENTRIES];
    logic               unc_arr [ENTRIES];

    // state of the entry the update addresses
    logic       upd_hit;
    logic       wr_en;
    ctr_e       wr_ctr;
    logic [PC_W-1:0] wr_tgt;

    always_comb begin
        upd_hit = vld_vec[upd_idx] && (tag_arr[upd_idx] == upd_tag);
        // a hit always refreshes; a miss allocates only when taken
        wr_en   = upd_en && (upd_hit || upd_taken);
        wr_ctr  = upd_hit ? ctr_step(ctr_arr[upd_idx], upd_taken) : CTR_WT;
        wr_tgt  = upd_taken ? upd_target : tgt_arr[upd_idx];
    end

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        logic             v_q;
        logic [TAG_W-1:0] t_q;
        logic [PC_W-1:0]  a_q;
        ctr_e             c_q;
        logic             u_q;
        logic             sel;

        assign sel = wr_en && (upd_idx == IDX_W'(e));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   v_q <= 1'b0;
            else if (sel) v_q <= 1'b1;
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                t_q <= upd_tag;
                a_q <= wr_tgt;
                c_q <= wr_ctr;
                u_q <= upd_uncond;
            end
        end

        assign vld_vec[e] = v_q;
        assign tag_arr[e] = t_q;
        assign tgt_arr[e] = a_q;
        assign ctr_arr[e] = c_q;
        assign unc_arr[e] = u_q;
    end

    // read before write: the array flops change only at the edge
    assign lk_valid  = vld_vec[lk_idx];
    assign lk_tag    = tag_arr[lk_idx];
    assign lk_target = tgt_arr[lk_idx];
    assign lk_ctr    = ctr_arr[lk_idx];
    assign lk_uncond = unc_arr[lk_idx];

    // R4
    alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_taken) |=>
            (vld_vec[$past(upd_idx)] && tgt_arr[$past(upd_idx)] == $past(upd_target)));

    // R5
    no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_en || (!upd_taken && !upd_hit)) |=> (vld_vec == $past(vld_vec)));

    // R6
    ctr_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_hit && upd_taken && ctr_arr[upd_idx] == CTR_ST)
            |=> (ctr_arr[$past(upd_idx)] == CTR_ST));

    // R6
    ctr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_hit && !upd_taken && ctr_arr[upd_idx] == CTR_SNT)
            |=> (ctr_arr[$past(upd_idx)] == CTR_SNT));

    // R8
    keep_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_hit && !upd_taken)
            |=> (tgt_arr[$past(upd_idx)] == $past(tgt_arr[upd_idx])));

endmodule

// File: rtl/btb_lookup.sv
module btb_lookup
    import btb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int PC_W    = 32,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int TAG_W  = PC_W - IDX_W - 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  fetch_pc,
    output logic [IDX_W-1:0] lk_idx,
    input  logic             ent_valid,
    input  logic [TAG_W-1:0] ent_tag,
    input  logic [PC_W-1:0]  ent_target,
    input  ctr_e             ent_ctr,
    input  logic             ent_uncond,
    output logic             hit,
    output logic             taken,
    output logic             uncond,
    output logic [PC_W-1:0]  target,
    output logic [PC_W-1:0]  next_pc
);

    logic [TAG_W-1:0] pc_tag;
    logic [PC_W-1:0]  fall_pc;

    always_comb begin
        lk_idx  = fetch_pc[IDX_W+1:2];
        pc_tag  = fetch_pc[PC_W-1:IDX_W+2];
        fall_pc = fetch_pc + PC_W'(4);
        hit     = ent_valid && (ent_tag == pc_tag);
        uncond  = hit && ent_uncond;
        taken   = hit && (ent_uncond || ctr_says_taken(ent_ctr));
        target  = hit ? ent_target : '0;
        next_pc = taken ? ent_target : fall_pc;
    end

    // R3
    miss_falls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (!taken && next_pc == fetch_pc + PC_W'(4)));

    // R7
    uncond_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uncond |-> (taken && next_pc == target));

endmodule

// File: rtl/btb_resolve.sv
module btb_resolve
    import btb_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            res_valid,
    input  logic [PC_W-1:0] res_pc,
    input  logic            res_taken,
    input  logic [PC_W-1:0] res_target,
    input  logic            res_pred_taken,
    input  logic [PC_W-1:0] res_pred_target,
    output logic            accept,
    output logic            flush,
    output logic [PC_W-1:0] redirect_pc
);

    flush_e st_q, st_d;
    logic   mis;
    logic [PC_W-1:0] fix_pc;

    always_comb begin
        accept = res_valid && (st_q == FL_RUN);
        mis    = accept && ((res_pred_taken != res_taken) ||
                            (res_taken && (res_pred_target != res_target)));
        fix_pc = res_taken ? res_target : res_pc + PC_W'(4);
        unique case (st_q)
            FL_RUN:   st_d = mis ? FL_FLUSH : FL_RUN;
            FL_FLUSH: st_d = FL_RUN;
            default:  st_d = FL_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FL_RUN;
        else        st_q <= st_d;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   redirect_pc <= '0;
        else if (mis) redirect_pc <= fix_pc;
    end

    assign flush = (st_q == FL_FLUSH);

    // R11
    flush_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !flush);

    // R10
    no_false_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && res_pred_taken == res_taken &&
         (!res_taken || res_pred_target == res_target)) |=> !flush);

    // R9
    late_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && res_taken && !res_pred_taken)
            |=> (flush && redirect_pc == $past(res_target)));

    // R9
    wrong_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !res_taken && res_pred_taken)
            |=> (flush && redirect_pc == $past(res_pc) + PC_W'(4)));

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
    import btb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int PC_W    = 32,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int TAG_W  = PC_W - IDX_W - 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            pred_hit,
    output logic            pred_taken,
    output logic            pred_uncond,
    output logic [PC_W-1:0] pred_target,
    output logic [PC_W-1:0] next_pc,
    input  logic            res_valid,
    input  logic            res_is_branch,
    input  logic            res_uncond,
    input  logic [PC_W-1:0] res_pc,
    input  logic            res_taken,
    input  logic [PC_W-1:0] res_target,
    input  logic            res_pred_taken,
    input  logic [PC_W-1:0] res_pred_target,
    output logic            flush,
    output logic [PC_W-1:0] redirect_pc
);

    logic [IDX_W-1:0] lk_idx;
    logic             ent_valid;
    logic [TAG_W-1:0] ent_tag;
    logic [PC_W-1:0]  ent_target;
    ctr_e             ent_ctr;
    logic             ent_uncond;
    logic             accept;
    logic             upd_en;

    assign upd_en = accept && res_is_branch;

    btb_lookup #(.ENTRIES(ENTRIES), .PC_W(PC_W)) u_lookup (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_pc   (fetch_pc),
        .lk_idx     (lk_idx),
        .ent_valid  (ent_valid),
        .ent_tag    (ent_tag),
        .ent_target (ent_target),
        .ent_ctr    (ent_ctr),
        .ent_uncond (ent_uncond),
        .hit        (pred_hit),
        .taken      (pred_taken),
        .uncond     (pred_uncond),
        .target     (pred_target),
        .next_pc    (next_pc)
    );

    btb_store #(.ENTRIES(ENTRIES), .PC_W(PC_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_idx     (lk_idx),
        .lk_valid   (ent_valid),
        .lk_tag     (ent_tag),
        .lk_target  (ent_target),
        .lk_ctr     (ent_ctr),
        .lk_uncond  (ent_uncond),
        .upd_en     (upd_en),
        .upd_idx    (res_pc[IDX_W+1:2]),
        .upd_tag    (res_pc[PC_W-1:IDX_W+2]),
        .upd_taken  (res_taken),
        .upd_uncond (res_uncond),
        .upd_target (res_target)
    );

    btb_resolve #(.PC_W(PC_W)) u_resolve (
        .clk             (clk),
        .rst_n           (rst_n),
        .res_valid       (res_valid),
        .res_pc          (res_pc),
        .res_taken       (res_taken),
        .res_target      (res_target),
        .res_pred_taken  (res_pred_taken),
        .res_pred_target (res_pred_target),
        .accept          (accept),
        .flush           (flush),
        .redirect_pc     (redirect_pc)
    );

endmodule

// File: tb/test_btb_predictor.sv
module test_btb_predictor;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] fetch_pc;
    logic        pred_hit, pred_taken, pred_uncond, flush;
    logic [31:0] pred_target, next_pc, redirect_pc;
    logic        res_valid, res_is_branch, res_uncond, res_taken, res_pred_taken;
    logic [31:0] res_pc, res_target, res_pred_target;

    int n_tests = 0;
    int n_fail  = 0;

    // reference model state
    bit          m_vld [64];
    logic [23:0] m_tag [64];
    logic [31:0] m_tgt [64];
    int          m_ctr [64];
    bit          m_unc [64];
    bit          m_flush;
    logic [31:0] m_redir;

    always #5 clk = ~clk;

    btb_predictor i_btb_predictor (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
        .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_uncond(pred_uncond),
        .pred_target(pred_target), .next_pc(next_pc),
        .res_valid(res_valid), .res_is_branch(res_is_branch), .res_uncond(res_uncond),
        .res_pc(res_pc), .res_taken(res_taken), .res_target(res_target),
        .res_pred_taken(res_pred_taken), .res_pred_target(res_pred_target),
        .flush(flush), .redirect_pc(redirect_pc)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // one clock: compare against the model, then advance the model at the edge
    task automatic cyc(string req);
        int   ix;
        bit   hit, tk, acc, mis;
        #1;
        ix  = int'(fetch_pc[7:2]);
        hit = m_vld[ix] && (m_tag[ix] == fetch_pc[31:8]);
        tk  = hit && (m_unc[ix] || m_ctr[ix] >= 2);
        chk(req, "hit", {31'd0, pred_hit}, {31'd0, hit});
        chk(req, "taken", {31'd0, pred_taken}, {31'd0, tk});
        chk(req, "uncond", {31'd0, pred_uncond}, {31'd0, hit && m_unc[ix]});
        chk(req, "target", pred_target, hit ? m_tgt[ix] : 32'd0);
        chk(req, "next_pc", next_pc, tk ? m_tgt[ix] : fetch_pc + 32'd4);
        chk(req, "flush", {31'd0, flush}, {31'd0, m_flush});
        chk(req, "redirect", redirect_pc, m_redir);
        @(posedge clk);
        acc = res_valid && !m_flush;
        mis = acc && ((res_pred_taken != res_taken) ||
                      (res_taken && res_pred_target != res_target));
        if (acc && res_is_branch) begin
            ix  = int'(res_pc[7:2]);
            hit = m_vld[ix] && (m_tag[ix] == res_pc[31:8]);
            if (hit) begin
                if (res_taken) begin
                    m_ctr[ix] = (m_ctr[ix] == 3) ? 3 : m_ctr[ix] + 1;
                    m_tgt[ix] = res_target;
                end else begin
                    m_ctr[ix] = (m_ctr[ix] == 0) ? 0 : m_ctr[ix] - 1;
                end
                m_unc[ix] = res_uncond;
            end else if (res_taken) begin
                m_vld[ix] = 1'b1;
                m_tag[ix] = res_pc[31:8];
                m_tgt[ix] = res_target;
                m_ctr[ix] = 2;
                m_unc[ix] = res_uncond;
            end
        end
        if (mis) m_redir = res_taken ? res_target : res_pc + 32'd4;
        m_flush = mis;
        @(negedge clk);
    endtask

    // present one resolve, then one quiet cycle
    task automatic rv(string req, bit br, bit unc, logic [31:0] pc, bit tk,
                      logic [31:0] tgt, bit ptk, logic [31:0] ptgt);
        res_valid = 1'b1; res_is_branch = br; res_uncond = unc; res_pc = pc;
        res_taken = tk; res_target = tgt; res_pred_taken = ptk; res_pred_target = ptgt;
        cyc(req);
        res_valid = 1'b0;
        cyc(req);
    endtask

    localparam logic [31:0] PA = 32'h0000_1040;
    localparam logic [31:0] PB = 32'h0000_3080;
    localparam logic [31:0] PC_ALIAS = PA + 32'd256;
    localparam logic [31:0] T1 = 32'h0000_2000;
    localparam logic [31:0] T2 = 32'h0000_2400;
    localparam logic [31:0] T3 = 32'h0000_5000;
    localparam logic [31:0] T4 = 32'h0000_6000;

    initial begin
        rst_n = 1'b0; fetch_pc = '0; res_valid = 1'b0; res_is_branch = 1'b0;
        res_uncond = 1'b0; res_pc = '0; res_taken = 1'b0; res_target = '0;
        res_pred_taken = 1'b0; res_pred_target = '0;
        m_flush = 1'b0; m_redir = '0;
        for (int i = 0; i < 64; i++) begin
            m_vld[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0; m_ctr[i] = 0; m_unc[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: empty after reset
        fetch_pc = PA; cyc("R1");
        for (int i = 0; i < 64; i++) begin
            fetch_pc = 32'(i * 4); cyc("R1");
        end
        // R3: miss falls through
        fetch_pc = 32'hFFFF_FFFC; cyc("R3");

        // R5: not-taken miss and non-branch leave the table alone
        fetch_pc = PA;
        rv("R5", 1, 0, PA, 0, T1, 0, 32'd0);
        rv("R5", 0, 0, PA, 1, T1, 1, T1);

        // R12 then R4: allocation seen only from the next cycle
        res_valid = 1'b1; res_is_branch = 1'b1; res_uncond = 1'b0; res_pc = PA;
        res_taken = 1'b1; res_target = T1; res_pred_taken = 1'b0; res_pred_target = '0;
        cyc("R12");
        // R11: flush cycle, this wrong-path resolve must be dropped
        res_taken = 1'b0; res_pred_taken = 1'b1; res_pred_target = T1;
        cyc("R11");
        res_valid = 1'b0;
        cyc("R4");
        cyc("R11");

        // R6 / R9 / R10: counter walk on entry A
        rv("R9", 1, 0, PA, 0, T1, 1, T1);      // case predicted taken, not taken
        cyc("R6");
        rv("R9", 1, 0, PA, 1, T1, 0, 32'd0);   // case predicted not taken, taken
        rv("R10", 1, 0, PA, 1, T1, 1, T1);     // counter to 3, correct
        rv("R6", 1, 0, PA, 1, T1, 1, T1);      // saturates at 3
        rv("R6", 1, 0, PA, 0, T1, 1, T1);      // 2, still predicts taken
        cyc("R6");
        rv("R6", 1, 0, PA, 0, T1, 1, T1);      // 1
        rv("R6", 1, 0, PA, 0, T1, 0, 32'd0);   // 0
        rv("R6", 1, 0, PA, 0, T1, 0, 32'd0);   // floor
        rv("R6", 1, 0, PA, 1, T1, 0, 32'd0);   // 1
        cyc("R6");

        // R8 / R9: taken with a different target
        rv("R9", 1, 0, PA, 1, T2, 1, T1);
        cyc("R8");
        rv("R8", 1, 0, PA, 0, T3, 1, T2);      // not taken keeps T2
        cyc("R8");

        // R7: unconditional wins over a low counter
        fetch_pc = PB;
        rv("R7", 1, 0, PB, 1, T3, 0, 32'd0);
        rv("R7", 1, 0, PB, 0, T3, 1, T3);
        rv("R7", 1, 0, PB, 0, T3, 0, 32'd0);
        rv("R7", 1, 1, PB, 1, T3, 0, 32'd0);
        cyc("R7");

        // R2: same index, different tag
        fetch_pc = PC_ALIAS; cyc("R2");
        rv("R2", 1, 0, PC_ALIAS, 1, T4, 0, 32'd0);
        cyc("R2");
        fetch_pc = PA; cyc("R2");

        // R9: a non-branch that was predicted taken
        rv("R9", 0, 0, 32'h0000_7000, 0, 32'd0, 1, T1);
        cyc("R10");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule